// File: doc/BRIEF.md
# Memory-Mapped LED and Switch Port

This block is a small APB completer that hangs off a peripheral bus. It holds two 32-bit word registers that software can write and read back, drives a single LED from the lowest bit of the first register, and lets software read the level of one push switch. Only the low byte of the bus address is decoded. The block answers every transfer at once: it never stalls and never signals an error.

A transfer has two phases. In the setup cycle, select is high and enable is low. In the access cycle that follows, both are high. The completer latches read data at the end of the setup cycle, so the value stays steady for the whole access cycle. A write lands at the end of the access cycle.

The register map uses word offsets within the low address byte:
- 0x00 is the LED register, which can be read and written.
- 0x04 is the scratch register, which can be read and written.
- 0x08 is the switch level, which is read-only.
- Every other offset reads as zero, and writes to it are dropped.

Top module: `apb_led_switch_port`

## Requirements
- R1: After the active-low reset, both registers are zero, the LED output is low and the read data output is zero.
- R2: A write to offset 0x00 stores the write data into the LED register. Reading offset 0x00 afterwards returns that value.
- R3: A write to offset 0x04 stores the write data into the scratch register. Reading offset 0x04 returns it, and the LED register is left untouched.
- R4: A register changes only on a clock edge where select, enable and the write flag are all high. A setup cycle alone, enable without select, or a read never alters either register or the LED.
- R5: The LED output equals bit 0 of the LED register, and it takes the new value one clock edge after the write.
- R6: A read of offset 0x08 returns the switch level in bit 0: 1 when pressed, 0 when released. Bits 31 to 1 are zero.
- R7: Reads of any offset other than 0x00, 0x04 and 0x08 return zero. Writes to those offsets, and to 0x08, change no register.
- R8: Address bits above bit 7 are ignored. For example, 0x1004 reaches the scratch register.
- R9: The ready output is always high and the error output is always low.
- R10: Read data is captured on the edge that ends the setup cycle of a read. It stays unchanged through the access cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Completer select |
| bus_en | input | 1 | High in the access cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rdy | output | 1 | Ready, tied high |
| bus_err | output | 1 | Error, tied low |
| switch_i | input | 1 | Switch level, 1 = pressed |
| led_o | output | 1 | LED drive, bit 0 of the LED register |

## Verification
The assertions expect well-formed transfers:
- The address and the write flag are held from the setup cycle into the access cycle.
- The switch input is steady around each clock edge.

The bench meets these conditions because it drives every input on the falling edge, through tasks that produce a setup cycle followed by one access cycle. The only exception is the malformed phases used for R4. Those are deliberately incomplete, so that the bench can show they leave the registers unchanged.

// File: rtl/apb_led_pkg.sv
package apb_led_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int DEC_W  = 8;

  localparam logic [DEC_W-1:0] OFS_LED    = 8'h00;
  localparam logic [DEC_W-1:0] OFS_SCRATCH = 8'h04;
  localparam logic [DEC_W-1:0] OFS_SWITCH = 8'h08;

  typedef enum logic [1:0] {
    TGT_NONE    = 2'd0,
    TGT_LED     = 2'd1,
    TGT_SCRATCH = 2'd2,
    TGT_SWITCH  = 2'd3
  } target_e;
endpackage

// File: rtl/apbled_decode.sv
module apbled_decode
  import apb_led_pkg::*;
#(
  parameter int DW = DEC_W
) (
  input  logic [DW-1:0] ofs,
  output target_e       tgt
);
  always_comb begin
    if (ofs == OFS_LED[DW-1:0])          tgt = TGT_LED;
    else if (ofs == OFS_SCRATCH[DW-1:0]) tgt = TGT_SCRATCH;
    else if (ofs == OFS_SWITCH[DW-1:0])  tgt = TGT_SWITCH;
    else                                 tgt = TGT_NONE;
  end
endmodule

// File: rtl/apbled_regs.sv
module apbled_regs
  import apb_led_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_fire,
  input  target_e      tgt,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] led_reg,
  output logic [W-1:0] scr_reg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_reg <= '0;
      scr_reg <= '0;
    end else if (wr_fire) begin
      if (tgt == TGT_LED)     led_reg <= wdata;
      if (tgt == TGT_SCRATCH) scr_reg <= wdata;
    end
  end

  // R4: no write strobe, no register change
  p_hold_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> ($stable(led_reg) && $stable(scr_reg)));

  // R3: scratch write leaves LED register alone
  p_scratch_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && tgt == TGT_SCRATCH) |=> (scr_reg == $past(wdata) && $stable(led_reg)));
endmodule

// File: rtl/apbled_rdmux.sv
module apbled_rdmux
  import apb_led_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         hold,
  input  target_e      tgt,
  input  logic [W-1:0] led_reg,
  input  logic [W-1:0] scr_reg,
  input  logic         sw,
  output logic [W-1:0] rdata
);
  logic [W-1:0] sel_data;

  always_comb begin
    unique case (tgt)
      TGT_LED:     sel_data = led_reg;
      TGT_SCRATCH: sel_data = scr_reg;
      TGT_SWITCH:  sel_data = {{(W-1){1'b0}}, sw};
      default:     sel_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata <= '0;
    else if (cap) rdata <= sel_data;
  end

  // R10: read data does not move across the access edge
  p_rdata_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(rdata));

  // R6: switch read is zero-extended level
  p_switch_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && tgt == TGT_SWITCH) |=> (rdata == {{(W-1){1'b0}}, $past(sw)}));
endmodule

// File: rtl/apb_led_switch_port.sv
module apb_led_switch_port
  import apb_led_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int OW = DEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rdy,
  output logic          bus_err,
  input  logic          switch_i,
  output logic          led_o
);
  target_e       tgt;
  logic          wr_fire;
  logic          rd_cap;
  logic          acc_hold;
  logic [DW-1:0] led_reg;
  logic [DW-1:0] scr_reg;
  logic          unused_addr_hi;

  assign unused_addr_hi = ^bus_addr[AW-1:OW];

  assign wr_fire  = bus_sel & bus_en & bus_wr;
  assign rd_cap   = bus_sel & ~bus_en & ~bus_wr;
  assign acc_hold = bus_sel & bus_en;

  apbled_decode #(.DW(OW)) u_dec (
    .ofs (bus_addr[OW-1:0]),
    .tgt (tgt)
  );

  apbled_regs #(.W(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .tgt     (tgt),
    .wdata   (bus_wdata),
    .led_reg (led_reg),
    .scr_reg (scr_reg)
  );

  apbled_rdmux #(.W(DW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (rd_cap),
    .hold    (acc_hold),
    .tgt     (tgt),
    .led_reg (led_reg),
    .scr_reg (scr_reg),
    .sw      (switch_i),
    .rdata   (bus_rdata)
  );

  assign led_o   = led_reg[0];
  assign bus_rdy = 1'b1;
  assign bus_err = 1'b0;

  // R9: never stalls, never errors
  p_no_wait_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy && !bus_err);

  // R5: LED follows bit 0 of data written to offset 0x00
  p_led_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bus_addr[OW-1:0] == OFS_LED[OW-1:0]) |=> (led_o == $past(bus_wdata[0])));
endmodule

// File: tb/test_apb_led_switch_port.sv
module test_apb_led_switch_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rdy, bus_err;
  logic        switch_i = 1'b0;
  logic        led_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  apb_led_switch_port i_apb_led_switch_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .bus_err(bus_err), .switch_i(switch_i), .led_o(led_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_en = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 1;
    check("R9 ready", {31'b0, bus_rdy}, 32'd1);
    @(negedge clk); bus_sel = 0; bus_en = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_en = 0; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_en = 1; d = bus_rdata;
    check("R9 error", {31'b0, bus_err}, 32'd0);
    @(negedge clk);
    check("R10 stable in access", bus_rdata, d);
    bus_sel = 0; bus_en = 0;
  endtask

  task automatic t_reset_r1();
    logic [31:0] v;
    check("R1 led", {31'b0, led_o}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    bus_read(32'h00, v); check("R1 led reg", v, 32'd0);
    bus_read(32'h04, v); check("R1 scratch reg", v, 32'd0);
  endtask

  task automatic t_led_write_r2_r5();
    logic [31:0] v;
    bus_write(32'h00, 32'hA5A5_0001);
    check("R5 led on", {31'b0, led_o}, 32'd1);
    bus_read(32'h00, v); check("R2 readback", v, 32'hA5A5_0001);
    bus_write(32'h00, 32'h1234_5678);
    check("R5 led off", {31'b0, led_o}, 32'd0);
    bus_read(32'h00, v); check("R2 readback 2", v, 32'h1234_5678);
  endtask

  task automatic t_scratch_r3();
    logic [31:0] v;
    bus_write(32'h04, 32'hDEAD_BEEF);
    bus_read(32'h04, v); check("R3 scratch", v, 32'hDEAD_BEEF);
    bus_read(32'h00, v); check("R3 led untouched", v, 32'h1234_5678);
    check("R3 led pin", {31'b0, led_o}, 32'd0);
  endtask

  task automatic t_partial_r4();
    logic [31:0] v;
    @(negedge clk); bus_sel = 1; bus_en = 0; bus_wr = 1; bus_addr = 32'h00; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); bus_sel = 0; bus_en = 1;
    @(negedge clk); bus_en = 0; bus_wr = 0;
    check("R4 led after partial", {31'b0, led_o}, 32'd0);
    @(negedge clk); bus_sel = 1; bus_en = 0; bus_wr = 0; bus_addr = 32'h04; bus_wdata = 32'h0;
    @(negedge clk); bus_en = 1;
    @(negedge clk); bus_sel = 0; bus_en = 0;
    bus_read(32'h00, v); check("R4 led reg", v, 32'h1234_5678);
    bus_read(32'h04, v); check("R4 scratch reg", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_switch_r6();
    logic [31:0] v;
    switch_i = 1;
    bus_read(32'h08, v); check("R6 pressed", v, 32'd1);
    switch_i = 0;
    bus_read(32'h08, v); check("R6 released", v, 32'd0);
  endtask

  task automatic t_unmapped_r7();
    logic [31:0] v;
    bus_read(32'h0C, v); check("R7 read 0x0C", v, 32'd0);
    bus_read(32'h02, v); check("R7 read 0x02", v, 32'd0);
    bus_write(32'h0C, 32'h5555_5555);
    bus_write(32'h08, 32'h7777_7777);
    bus_write(32'hFC, 32'h9999_9999);
    bus_read(32'h00, v); check("R7 led reg kept", v, 32'h1234_5678);
    bus_read(32'h04, v); check("R7 scratch kept", v, 32'hDEAD_BEEF);
    bus_read(32'h08, v); check("R7 switch kept", v, 32'd0);
  endtask

  task automatic t_high_addr_r8();
    logic [31:0] v;
    bus_write(32'h0000_1004, 32'hCAFE_F00D);
    bus_read(32'h04, v); check("R8 scratch via 0x1004", v, 32'hCAFE_F00D);
    bus_write(32'hFFFF_FF00, 32'h0000_0003);
    check("R8 led via high addr", {31'b0, led_o}, 32'd1);
    bus_read(32'h0000_1000, v); check("R8 read 0x1000", v, 32'h3);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_r1();
    t_led_write_r2_r5();
    t_scratch_r3();
    t_partial_r4();
    t_switch_r6();
    t_unmapped_r7();
    t_high_addr_r8();
    check("R9 final ready", {31'b0, bus_rdy}, 32'd1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule